// File: doc/BRIEF.md
# VS-level virtual interrupt resolver

This block decides, every cycle, whether an interrupt is waiting for a virtualized guest running in VS mode and which cause number the trap logic should report for it. It draws on two sources. The first is interrupts that machine and hypervisor delegation both pass down to the guest. The second is interrupts the hypervisor injects itself, which need no physical source. The two are merged into a single candidate vector. The block picks one winner under a fixed priority, restores the cause numbering, and flags whether the trap must be taken in VS mode.

Before arbitration, the three VS-level standard bits of the delegated set are moved down one position so that they line up with their supervisor-level equivalents. After arbitration, a low-numbered winner has one added back to its cause number. All outputs are registered once, so results appear one clock after the inputs.

Top module: `vs_irq_resolver`

## Requirements
- R1: The delegated set is `mip & mideleg & hideleg`. Within it, bits 2, 6 and 10 are moved to positions 1, 5 and 9, and all other bits keep their place.
- R2: The injected set is `hvip & hvien & ~hideleg & vsie`. It is ORed with the renumbered delegated set to form the candidate vector.
- R3: When `vs_ie` is low, the candidate vector is treated as empty. The next cycle then shows `irq_valid` low.
- R4: Among candidates, position 9 wins first, then position 1, then position 5. After those, the lowest remaining index wins.
- R5: If the winning position is 13 or higher, `irq_cause` equals that position. If the winning position is below 13, `irq_cause` is the position plus one.
- R6: `to_vs` is high when `virt_on` is high and either `hideleg[irq_cause]` is set, or `hvip[irq_cause]` and `hvien[irq_cause]` are set while `mip[irq_cause]` is clear.
- R7: When there is no candidate, `irq_valid` is low, `irq_cause` is 0 and `to_vs` is low.
- R8: `wake` is high when the candidate vector is nonzero before the `vs_ie` gating is applied.
- R9: All outputs are registered and reflect the inputs of the previous rising clock edge. All outputs are zero while reset is held and in the first cycle after reset.
- R10: An injected interrupt is pending when its `hvip`, `hvien` and `vsie` bits are set, `hideleg` is clear, and `mip` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mip | input | N | Machine pending vector |
| mideleg | input | N | Machine-to-supervisor delegation |
| hideleg | input | N | Hypervisor-to-VS delegation |
| hvip | input | N | Hypervisor-injected pending bits |
| hvien | input | N | Hypervisor injection enables |
| vsie | input | N | VS interrupt enable register |
| vs_ie | input | 1 | Global VS interrupt enable |
| virt_on | input | 1 | Virtualization active |
| irq_valid | output | 1 | An interrupt is selected |
| irq_cause | output | $clog2(N) | Reported cause number |
| to_vs | output | 1 | Trap is taken in VS mode |
| wake | output | 1 | Ungated candidate vector is nonzero |

## Verification
The assertions check on every cycle the rules that link inputs to outputs without needing the full priority order. These are: the idle output state, the gating by the global enable, `valid` implying `wake`, the absence of `to_vs` outside virtualization, and the supervisor external interrupt winning over everything else.

Only the bench scenarios can show the following: the ordering among the other candidates, the exact cause renumbering at the boundary near position 13, the renumbering of the delegated VS bits, and injection without a real source. The bench checks these against a reference model in its own code.

// File: rtl/vs_irq_resolver.sv
module vs_irq_resolver #(
  parameter int N = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         mip,
  input  logic [N-1:0]         mideleg,
  input  logic [N-1:0]         hideleg,
  input  logic [N-1:0]         hvip,
  input  logic [N-1:0]         hvien,
  input  logic [N-1:0]         vsie,
  input  logic                 vs_ie,
  input  logic                 virt_on,
  output logic                 irq_valid,
  output logic [$clog2(N)-1:0] irq_cause,
  output logic                 to_vs,
  output logic                 wake
);
  localparam int CW    = $clog2(N);
  localparam int P_EXT = 9;
  localparam int P_SW  = 1;
  localparam int P_TM  = 5;
  localparam int LOW_LIMIT = 12;
  localparam logic [N-1:0] VS_BITS = N'((64'd1 << 2) | (64'd1 << 6) | (64'd1 << 10));

  logic [N-1:0]  deleg, deleg_ren, injected, cand_raw, cand;
  logic [CW-1:0] win, cause_nx;
  logic          hit, inj_hit, vs_nx;

  assign deleg     = mip & mideleg & hideleg;
  assign deleg_ren = (deleg & ~VS_BITS) | ((deleg & VS_BITS) >> 1);
  assign injected  = hvip & hvien & ~hideleg & vsie;
  assign cand_raw  = deleg_ren | injected;
  assign cand      = vs_ie ? cand_raw : '0;
  assign hit       = |cand;

  function automatic logic [CW-1:0] pick(input logic [N-1:0] v);
    logic [CW-1:0] p;
    p = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i] && i != P_EXT && i != P_SW && i != P_TM) p = CW'(i);
    if (v[P_TM])  p = CW'(P_TM);
    if (v[P_SW])  p = CW'(P_SW);
    if (v[P_EXT]) p = CW'(P_EXT);
    return p;
  endfunction

  assign win      = pick(cand);
  assign cause_nx = (win > CW'(LOW_LIMIT)) ? win : win + CW'(1);
  assign inj_hit  = hvip[cause_nx] & hvien[cause_nx] & ~mip[cause_nx];
  assign vs_nx    = virt_on & (hideleg[cause_nx] | inj_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_cause <= '0;
      to_vs     <= 1'b0;
      wake      <= 1'b0;
    end else begin
      irq_valid <= hit;
      irq_cause <= hit ? cause_nx : '0;
      to_vs     <= hit & vs_nx;
      wake      <= |cand_raw;
    end
  end
endmodule

module vs_irq_resolver_chk #(
  parameter int N = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         mip,
  input logic [N-1:0]         mideleg,
  input logic [N-1:0]         hideleg,
  input logic                 vs_ie,
  input logic                 virt_on,
  input logic                 irq_valid,
  input logic [$clog2(N)-1:0] irq_cause,
  input logic                 to_vs,
  input logic                 wake
);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_cause == '0 && !to_vs));

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_ie |=> !irq_valid);

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> wake);

  assert_novirt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !virt_on |=> !to_vs);

  assert_ext_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_ie && mip[10] && mideleg[10] && hideleg[10]) |=> (irq_valid && irq_cause == 10));

  assert_cause_nz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_cause != '0);
endmodule

bind vs_irq_resolver vs_irq_resolver_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .mip(mip), .mideleg(mideleg), .hideleg(hideleg),
  .vs_ie(vs_ie), .virt_on(virt_on), .irq_valid(irq_valid),
  .irq_cause(irq_cause), .to_vs(to_vs), .wake(wake)
);

// File: tb/tb_vs_irq_resolver.sv
module tb_vs_irq_resolver;
  localparam int N = 64;
  localparam int CW = 6;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] mip = '0, mideleg = '0, hideleg = '0, hvip = '0, hvien = '0, vsie = '0;
  logic vs_ie = 1'b0, virt_on = 1'b0;
  logic irq_valid, to_vs, wake;
  logic [CW-1:0] irq_cause;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vs_irq_resolver #(.N(N)) dut (.*);

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic [N-1:0] cand_of(input logic gate);
    logic [N-1:0] d, c;
    d = mip & mideleg & hideleg;
    c = '0;
    for (int i = 0; i < N; i++) begin
      if (i == 2 || i == 6 || i == 10) c[i-1] = c[i-1] | d[i];
      else c[i] = c[i] | d[i];
    end
    for (int i = 0; i < N; i++)
      if (hvip[i] && hvien[i] && !hideleg[i] && vsie[i]) c[i] = 1'b1;
    return (gate && !vs_ie) ? '0 : c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_and_check();
    logic [N-1:0] c;
    int w, cause;
    logic ev, evs, ewake;
    c = cand_of(1'b1);
    ewake = |cand_of(1'b0);
    ev = |c;
    w = -1;
    if (c[9]) w = 9;
    else if (c[1]) w = 1;
    else if (c[5]) w = 5;
    else for (int i = 0; i < N; i++) if (w < 0 && c[i]) w = i;
    cause = !ev ? 0 : (w >= 13 ? w : w + 1);
    evs = ev && virt_on && (hideleg[cause] || (hvip[cause] && hvien[cause] && !mip[cause]));
    @(posedge clk); @(negedge clk);
    chk("R1/R2/R4 valid", 32'(irq_valid), 32'(ev));
    chk("R4/R5 cause", 32'(irq_cause), 32'(cause));
    chk("R6 to_vs", 32'(to_vs), 32'(evs));
    chk("R8 wake", 32'(wake), 32'(ewake));
  endtask

  task automatic clr();
    mip = '0; mideleg = '0; hideleg = '0; hvip = '0; hvien = '0; vsie = '0;
    vs_ie = 1'b1; virt_on = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R9 reset valid", 32'(irq_valid), 0);
    chk("R9 reset cause", 32'(irq_cause), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 post-reset wake", 32'(wake), 0);

    clr(); step_and_check();
    chk("R7 idle valid", 32'(irq_valid), 0);
    chk("R7 idle cause", 32'(irq_cause), 0);

    clr(); mip[6] = 1; mideleg[6] = 1; hideleg[6] = 1; step_and_check();
    chk("R1 bit 6 renumbered", 32'(irq_cause), 6);

    clr(); mip[10] = 1; mideleg = '1; hideleg = '1; mip[1] = 1; mip[20] = 1; step_and_check();
    chk("R4 external first", 32'(irq_cause), 10);

    clr(); mip[2] = 1; mip[6] = 1; mideleg = '1; hideleg = '1; step_and_check();
    chk("R4 position 1 before 5", 32'(irq_cause), 2);

    clr(); hvip[20] = 1; hvien[20] = 1; vsie[20] = 1; step_and_check();
    chk("R10 injected no source", 32'(irq_valid), 1);
    chk("R5 high cause unchanged", 32'(irq_cause), 20);
    chk("R6 injected to_vs", 32'(to_vs), 1);

    clr(); hvip[12] = 1; hvien[12] = 1; vsie[12] = 1; step_and_check();
    chk("R5 winner 12 plus one", 32'(irq_cause), 13);

    clr(); hvip[13] = 1; hvien[13] = 1; vsie[13] = 1; step_and_check();
    chk("R5 winner 13 unchanged", 32'(irq_cause), 13);

    clr(); hvip[30] = 1; hvien[30] = 1; vsie[30] = 1; hideleg[30] = 1; step_and_check();
    chk("R2 hideleg blocks injection", 32'(irq_valid), 0);

    clr(); hvip[30] = 1; hvien[30] = 1; vsie[30] = 1; vs_ie = 0; step_and_check();
    chk("R3 gated valid", 32'(irq_valid), 0);
    chk("R8 wake ungated", 32'(wake), 1);

    clr(); hvip[40] = 1; hvien[40] = 1; vsie[40] = 1; virt_on = 0; step_and_check();
    chk("R6 no virt no to_vs", 32'(to_vs), 0);

    for (int k = 0; k < 3000; k++) begin
      mip     = {$urandom, $urandom} & {$urandom, $urandom};
      mideleg = {$urandom, $urandom} | {$urandom, $urandom};
      hideleg = {$urandom, $urandom} & {$urandom, $urandom};
      hvip    = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      hvien   = {$urandom, $urandom};
      vsie    = {$urandom, $urandom};
      if (k % 3 == 0) mip = mip & ~((64'd1 << 10) | (64'd1 << 2) | (64'd1 << 6) | 64'h3FF);
      vs_ie   = ($urandom % 5) != 0;
      virt_on = ($urandom % 4) != 0;
      step_and_check();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule